// File: doc/BRIEF.md
# Memory Access Ordering Queue

This block sits between an in-order allocation stage and a single data-memory port. It holds outstanding loads and stores in two circular queues and enforces the memory dependence rules between them. Allocation follows program order, so every queued entry is older than the access arriving on the allocate port.

A new load compares its address with all pending stores. If any match, it takes the data of the youngest matching store and never reads memory. Otherwise it issues a read when it reaches the head of the load queue. Results leave in load allocation order, each with the tag given at allocation. A new store records which pending, memory-reading loads target the same address. It may not write until all of them have delivered their results. Stores write only from the head of their queue and strictly in arrival order, so the youngest store to an address writes last.

The memory port carries one request per handshake and allows one read in flight. Read data comes back on a separate return strobe. Queue depths and all widths are parameters.

Top module: `mem_order_unit`

## Requirements
- R1: After reset, alloc_ready_o is 1 for both operation kinds, and mem_req_valid_o and res_valid_o are 0.
- R2: A load allocated while an older store to the same address is pending returns that store's data and issues no memory read. Its result appears the cycle after it reaches the load queue head.
- R3: When several pending stores match a load's address, the load receives the data of the most recently allocated of them.
- R4: A load with no matching store issues a read (mem_req_write_o = 0) at its own address. At most one read is in flight. res_valid_o rises the cycle after mem_rd_valid_i, carrying the returned data and the load's tag.
- R5: Load results leave in load allocation order, one per cycle at most. Each carries the tag and value defined by program-order execution.
- R6: A store is not written to memory until every older load to the same address that reads memory has delivered its result.
- R7: Stores write (mem_req_write_o = 1) only from the store queue head, in arrival order, one per accepted request. After draining, each address holds the data of its youngest store.
- R8: alloc_ready_o is 0 when the queue chosen by alloc_is_store_i (1 = store, 0 = load) is full. A refused allocation has no effect on results or memory.
- R9: While mem_req_valid_o is 1 and mem_req_ready_i is 0, the request stays valid with unchanged kind and address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_is_store_i | input | 1 | 1 = store, 0 = load |
| alloc_addr_i | input | ADDR_W | Access address |
| alloc_data_i | input | DATA_W | Store data |
| alloc_tag_i | input | TAG_W | Load tag returned with the result |
| alloc_ready_o | output | 1 | Target queue has room |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_write_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | ADDR_W | Request address |
| mem_req_wdata_o | output | DATA_W | Write data |
| mem_rd_valid_i | input | 1 | Read data return strobe |
| mem_rd_data_i | input | DATA_W | Returned read data |
| res_valid_o | output | 1 | Load result valid |
| res_tag_o | output | TAG_W | Load result tag |
| res_data_o | output | DATA_W | Load result value |

## Verification
The bench checks every load result against the program-order value, so faults in the internal state show up as wrong values at the result port. A dropped or misplaced wait bit lets a store overwrite memory before an older load's read. That load then returns the new value, which shows within the read latency of the collision. A wrong forwarding choice or a stale age pointer shows as a wrong value on the very next result. Broken store ordering shows as a mismatch in the final memory image once the queues drain, and a lost queue entry shows as missing or shifted tags at the result port.

// File: rtl/mou_pkg.sv
package mou_pkg;
  typedef enum logic {
    SEL_LOAD  = 1'b0,
    SEL_STORE = 1'b1
  } mem_sel_e;
endpackage

// File: rtl/mou_load_queue.sv
module mou_load_queue #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  input  logic              alloc_fwd_i,
  input  logic [DATA_W-1:0] alloc_data_i,
  output logic              full_o,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic [DEPTH-1:0]  lk_mask_o,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              chk_hit_o,
  output logic              head_valid_o,
  output logic              head_fwd_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [TAG_W-1:0]  head_tag_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic [$clog2(DEPTH)-1:0] head_idx_o,
  input  logic              pop_i
);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0]  valid_q, fwd_q;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [IW-1:0]     head_q, tail_q;
  logic [IW:0]       count_q;
  logic [DEPTH-1:0]  chk_vec;

  assign full_o = (count_q == (IW+1)'(DEPTH));

  // only loads that read memory matter for store ordering
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign lk_mask_o[g] = valid_q[g] && !fwd_q[g] && (addr_q[g] == lk_addr_i);
    assign chk_vec[g]   = valid_q[g] && !fwd_q[g] && (addr_q[g] == chk_addr_i);
  end
  assign chk_hit_o = |chk_vec;

  assign head_valid_o = valid_q[head_q];
  assign head_fwd_o   = fwd_q[head_q];
  assign head_addr_o  = addr_q[head_q];
  assign head_tag_o   = tag_q[head_q];
  assign head_data_o  = data_q[head_q];
  assign head_idx_o   = head_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      fwd_q   <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (alloc_i) begin
        valid_q[tail_q] <= 1'b1;
        fwd_q[tail_q]   <= alloc_fwd_i;
        tail_q          <= tail_q + 1'b1;
      end
      if (pop_i) begin
        valid_q[head_q] <= 1'b0;
        head_q          <= head_q + 1'b1;
      end
      count_q <= count_q + (IW+1)'(alloc_i) - (IW+1)'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_i) begin
      addr_q[tail_q] <= alloc_addr_i;
      data_q[tail_q] <= alloc_data_i;
      tag_q[tail_q]  <= alloc_tag_i;
    end
  end

  AST_LQ_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o); // R8
  AST_LQ_POP_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> head_valid_o); // R5
endmodule

// File: rtl/mou_store_queue.sv
module mou_store_queue #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 8,
  parameter int LQ_DEPTH = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_i,
  input  logic [ADDR_W-1:0]   alloc_addr_i,
  input  logic [DATA_W-1:0]   alloc_data_i,
  input  logic [LQ_DEPTH-1:0] alloc_wait_i,
  output logic                full_o,
  input  logic [ADDR_W-1:0]   lk_addr_i,
  output logic                lk_hit_o,
  output logic [DATA_W-1:0]   lk_data_o,
  input  logic [LQ_DEPTH-1:0] ld_clr_i,
  output logic                head_valid_o,
  output logic                head_ready_o,
  output logic [ADDR_W-1:0]   head_addr_o,
  output logic [DATA_W-1:0]   head_data_o,
  input  logic                pop_i
);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0]                valid_q;
  logic [DEPTH-1:0][LQ_DEPTH-1:0]  wait_q;
  logic [ADDR_W-1:0]               addr_q [DEPTH];
  logic [DATA_W-1:0]               data_q [DEPTH];
  logic [IW-1:0]                   head_q, tail_q;
  logic [IW:0]                     count_q;

  assign full_o = (count_q == (IW+1)'(DEPTH));

  // walk oldest to youngest; the last hit is the youngest match
  always_comb begin
    logic [IW-1:0] idx;
    lk_hit_o  = 1'b0;
    lk_data_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_q + IW'(k);
      if (valid_q[idx] && (addr_q[idx] == lk_addr_i)) begin
        lk_hit_o  = 1'b1;
        lk_data_o = data_q[idx];
      end
    end
  end

  assign head_valid_o = valid_q[head_q];
  assign head_ready_o = valid_q[head_q] && (wait_q[head_q] == '0);
  assign head_addr_o  = addr_q[head_q];
  assign head_data_o  = data_q[head_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      wait_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        wait_q[i] <= wait_q[i] & ~ld_clr_i;
      end
      if (alloc_i) begin
        valid_q[tail_q] <= 1'b1;
        wait_q[tail_q]  <= alloc_wait_i;
        tail_q          <= tail_q + 1'b1;
      end
      if (pop_i) begin
        valid_q[head_q] <= 1'b0;
        head_q          <= head_q + 1'b1;
      end
      count_q <= count_q + (IW+1)'(alloc_i) - (IW+1)'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_i) begin
      addr_q[tail_q] <= alloc_addr_i;
      data_q[tail_q] <= alloc_data_i;
    end
  end

  AST_SQ_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o); // R8
  AST_SQ_POP_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> head_ready_o); // R6
endmodule

// File: rtl/mem_order_unit.sv
module mem_order_unit #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 6,
  parameter int LQ_DEPTH = 8,
  parameter int SQ_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic              alloc_is_store_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [DATA_W-1:0] alloc_data_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  output logic              alloc_ready_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_write_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic              mem_rd_valid_i,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic              res_valid_o,
  output logic [TAG_W-1:0]  res_tag_o,
  output logic [DATA_W-1:0] res_data_o
);
  import mou_pkg::*;
  localparam int LIW = $clog2(LQ_DEPTH);

  logic                lq_full, sq_full;
  logic                ld_alloc, st_alloc;
  logic                fwd_hit;
  logic [DATA_W-1:0]   fwd_data;
  logic [LQ_DEPTH-1:0] ld_match, ld_clr;
  logic                lq_head_valid, lq_head_fwd;
  logic [ADDR_W-1:0]   lq_head_addr;
  logic [TAG_W-1:0]    lq_head_tag;
  logic [DATA_W-1:0]   lq_head_data;
  logic [LIW-1:0]      lq_head_idx;
  logic                lq_pop;
  logic                sq_head_valid, sq_head_ready, sq_pop;
  logic [ADDR_W-1:0]   sq_head_addr;
  logic [DATA_W-1:0]   sq_head_data;
  logic                st_blk_hit;
  logic                rd_pending_q, rd_issue, rd_done, fwd_pop;
  logic                ld_need_rd, req_valid, hs;
  mem_sel_e            fresh_sel, sel, hold_sel_q;
  logic                hold_q;
  logic                res_valid_q;
  logic [TAG_W-1:0]    res_tag_q;
  logic [DATA_W-1:0]   res_data_q;

  assign alloc_ready_o = alloc_is_store_i ? !sq_full : !lq_full;
  assign ld_alloc      = alloc_valid_i && !alloc_is_store_i && !lq_full;
  assign st_alloc      = alloc_valid_i &&  alloc_is_store_i && !sq_full;

  // a load leaving this cycle must not be recorded as a blocker
  assign ld_clr = lq_pop ? ({{(LQ_DEPTH-1){1'b0}}, 1'b1} << lq_head_idx) : '0;

  mou_load_queue #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(LQ_DEPTH)
  ) u_lq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (ld_alloc),
    .alloc_addr_i (alloc_addr_i),
    .alloc_tag_i  (alloc_tag_i),
    .alloc_fwd_i  (fwd_hit),
    .alloc_data_i (fwd_data),
    .full_o       (lq_full),
    .lk_addr_i    (alloc_addr_i),
    .lk_mask_o    (ld_match),
    .chk_addr_i   (sq_head_addr),
    .chk_hit_o    (st_blk_hit),
    .head_valid_o (lq_head_valid),
    .head_fwd_o   (lq_head_fwd),
    .head_addr_o  (lq_head_addr),
    .head_tag_o   (lq_head_tag),
    .head_data_o  (lq_head_data),
    .head_idx_o   (lq_head_idx),
    .pop_i        (lq_pop)
  );

  mou_store_queue #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(SQ_DEPTH), .LQ_DEPTH(LQ_DEPTH)
  ) u_sq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (st_alloc),
    .alloc_addr_i (alloc_addr_i),
    .alloc_data_i (alloc_data_i),
    .alloc_wait_i (ld_match & ~ld_clr),
    .full_o       (sq_full),
    .lk_addr_i    (alloc_addr_i),
    .lk_hit_o     (fwd_hit),
    .lk_data_o    (fwd_data),
    .ld_clr_i     (ld_clr),
    .head_valid_o (sq_head_valid),
    .head_ready_o (sq_head_ready),
    .head_addr_o  (sq_head_addr),
    .head_data_o  (sq_head_data),
    .pop_i        (sq_pop)
  );

  // memory port: reads first, choice frozen while the port stalls
  assign ld_need_rd = lq_head_valid && !lq_head_fwd && !rd_pending_q;
  assign fresh_sel  = ld_need_rd ? SEL_LOAD : SEL_STORE;
  assign sel        = hold_q ? hold_sel_q : fresh_sel;
  assign req_valid  = hold_q || ld_need_rd || sq_head_ready;
  assign hs         = req_valid && mem_req_ready_i;
  assign sq_pop     = hs && (sel == SEL_STORE);
  assign rd_issue   = hs && (sel == SEL_LOAD);
  assign rd_done    = rd_pending_q && mem_rd_valid_i;
  assign fwd_pop    = lq_head_valid && lq_head_fwd;
  assign lq_pop     = rd_done || fwd_pop;

  assign mem_req_valid_o = req_valid;
  assign mem_req_write_o = (sel == SEL_STORE);
  assign mem_req_addr_o  = (sel == SEL_STORE) ? sq_head_addr : lq_head_addr;
  assign mem_req_wdata_o = sq_head_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pending_q <= 1'b0;
      hold_q       <= 1'b0;
      hold_sel_q   <= SEL_LOAD;
      res_valid_q  <= 1'b0;
      res_tag_q    <= '0;
      res_data_q   <= '0;
    end else begin
      if (rd_issue)     rd_pending_q <= 1'b1;
      else if (rd_done) rd_pending_q <= 1'b0;
      hold_q      <= req_valid && !mem_req_ready_i;
      hold_sel_q  <= sel;
      res_valid_q <= lq_pop;
      if (lq_pop) begin
        res_tag_q  <= lq_head_tag;
        res_data_q <= rd_done ? mem_rd_data_i : lq_head_data;
      end
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_tag_o   = res_tag_q;
  assign res_data_o  = res_data_q;

  AST_RD_TO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done |=> res_valid_o); // R4
  AST_ONE_READ_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pending_q |-> !(mem_req_valid_o && !mem_req_write_o)); // R4
  AST_FWD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lq_head_valid && lq_head_fwd) |=> res_valid_o); // R2
  AST_WAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_write_o && mem_req_ready_i) |-> !st_blk_hit); // R6
  AST_STORE_FROM_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_write_o) |-> sq_head_valid); // R7
  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_write_o) && $stable(mem_req_addr_o))); // R9
endmodule

// File: tb/mem_order_unit_test.sv
module mem_order_unit_test;
  localparam int AW = 4, DW = 8, TW = 4, LQD = 4, SQD = 4, LAT = 3;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          alloc_valid = 1'b0, alloc_is_store = 1'b0;
  logic [AW-1:0] alloc_addr = '0;
  logic [DW-1:0] alloc_data = '0;
  logic [TW-1:0] alloc_tag = '0;
  logic          alloc_ready;
  logic          req_valid, req_write;
  logic          req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          res_valid;
  logic [TW-1:0] res_tag;
  logic [DW-1:0] res_data;

  mem_order_unit #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .LQ_DEPTH(LQD), .SQ_DEPTH(SQD)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_is_store_i(alloc_is_store),
    .alloc_addr_i(alloc_addr), .alloc_data_i(alloc_data), .alloc_tag_i(alloc_tag),
    .alloc_ready_o(alloc_ready),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_write_o(req_write),
    .mem_req_addr_o(req_addr), .mem_req_wdata_o(req_wdata),
    .mem_rd_valid_i(rd_valid), .mem_rd_data_i(rd_data),
    .res_valid_o(res_valid), .res_tag_o(res_tag), .res_data_o(res_data)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, reads = 0, writes = 0, rdy_pct = 0, rd_cnt = 0;
  int exp_wr = 0, exp_rd = 0;
  logic [DW-1:0] mem_m [16];
  logic [DW-1:0] shadow [16];
  logic [TW-1:0] exp_tag [2048];
  logic [DW-1:0] exp_data [2048];
  logic [DW-1:0] rd_buf = '0, last_res = '0;
  logic [TW-1:0] tag_cnt = '0;

  function automatic logic [DW-1:0] init_val(int a);
    return DW'(a * 17 + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory model, result monitor and watchdog
  initial begin
    for (int a = 0; a < 16; a++) begin
      mem_m[a]  = init_val(a);
      shadow[a] = init_val(a);
    end
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(1'b0, "watchdog", cyc, 100000);
        finish_run();
      end
      if (rd_valid) chk(res_valid === 1'b1, "R4 result after return", int'(res_valid), 1);
      if (res_valid) begin
        if (exp_rd >= exp_wr) chk(1'b0, "R5 unexpected result", exp_rd, exp_wr);
        else begin
          chk(res_tag === exp_tag[exp_rd] && res_data === exp_data[exp_rd], "R5 tag/value",
              int'({res_tag, res_data}), int'({exp_tag[exp_rd], exp_data[exp_rd]}));
          exp_rd++;
        end
        last_res = res_data;
      end
      rd_valid = 1'b0;
      if (rd_cnt > 0) begin
        rd_cnt--;
        if (rd_cnt == 0) begin
          rd_valid = 1'b1;
          rd_data  = rd_buf;
        end
      end
      req_ready = ($urandom_range(99, 0) < rdy_pct);
      if (req_valid && req_ready) begin
        if (req_write) begin
          mem_m[req_addr] = req_wdata;
          writes++;
        end else begin
          rd_buf = mem_m[req_addr];
          rd_cnt = LAT;
          reads++;
        end
      end
    end
  end

  task automatic do_op(input bit st, input int a, input logic [DW-1:0] d);
    bit done = 1'b0;
    while (!done) begin
      @(negedge clk);
      alloc_valid    = 1'b1;
      alloc_is_store = st;
      alloc_addr     = AW'(a);
      alloc_data     = d;
      alloc_tag      = tag_cnt;
      #1;
      done = alloc_ready;
    end
    if (st) shadow[a] = d;
    else begin
      exp_tag[exp_wr]  = tag_cnt;
      exp_data[exp_wr] = shadow[a];
      exp_wr++;
      tag_cnt++;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    alloc_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int r0, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    alloc_is_store = 1'b1; #1;
    chk(alloc_ready === 1'b1, "R1 store ready", int'(alloc_ready), 1);
    alloc_is_store = 1'b0; #1;
    chk(alloc_ready === 1'b1, "R1 load ready", int'(alloc_ready), 1);
    chk(req_valid === 1'b0, "R1 no request", int'(req_valid), 0);
    chk(res_valid === 1'b0, "R1 no result", int'(res_valid), 0);

    // R2/R3: stores held back by a stalled port, then a load to the same address
    rdy_pct = 0;
    r0 = reads;
    do_op(1'b1, 5, 8'h11);
    do_op(1'b1, 5, 8'h22);
    do_op(1'b0, 5, 8'h00);
    idle(4);
    chk(exp_rd == exp_wr, "R2 forwarded result delivered", exp_rd, exp_wr);
    chk(reads == r0, "R2 no memory read", reads - r0, 0);
    chk(last_res == 8'h22, "R3 youngest store data", int'(last_res), 8'h22);

    // R8: fill the store queue, check ready per kind, refused store has no effect
    do_op(1'b1, 6, 8'h33);
    do_op(1'b1, 7, 8'h44);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_is_store = 1'b1; alloc_addr = 4'd9; alloc_data = 8'hEE; #1;
    chk(alloc_ready === 1'b0, "R8 store refused when full", int'(alloc_ready), 0);
    alloc_is_store = 1'b0; #1;
    chk(alloc_ready === 1'b1, "R8 load still accepted", int'(alloc_ready), 1);
    alloc_is_store = 1'b1;
    repeat (2) @(negedge clk);
    alloc_valid = 1'b0;
    w0 = writes;
    rdy_pct = 100;
    idle(20);
    chk(writes - w0 == 4, "R7 four stores written", writes - w0, 4);
    chk(mem_m[5] == 8'h22, "R7 last store wins", int'(mem_m[5]), 8'h22);
    chk(mem_m[9] == init_val(9), "R8 refused store absent", int'(mem_m[9]), int'(init_val(9)));

    // R6: a store right behind a load to the same address waits for its read
    do_op(1'b0, 3, 8'h00);
    do_op(1'b1, 3, 8'h5A);
    idle(15);
    chk(last_res == init_val(3), "R6 load sees old value", int'(last_res), int'(init_val(3)));
    chk(mem_m[3] == 8'h5A, "R7 store written after load", int'(mem_m[3]), 8'h5A);

    // sweep: mixed traffic with a stalling port (R4, R5, R6, R9 exercised)
    rdy_pct = 60;
    for (int i = 0; i < 600; i++) begin
      do_op(1'(($urandom_range(1, 0))), $urandom_range(7, 0), DW'($urandom_range(255, 0)));
      if ($urandom_range(3, 0) == 0) idle(0);
    end
    rdy_pct = 100;
    idle(60);
    chk(exp_rd == exp_wr, "R5 all results delivered", exp_rd, exp_wr);
    for (int a = 0; a < 16; a++)
      chk(mem_m[a] == shadow[a], "R7 final memory", int'(mem_m[a]), int'(shadow[a]));
    finish_run();
  end
endmodule